// File: doc/BRIEF.md
# Four-Channel Converter Scan Sequencer

The sequencer sits between a four-channel simultaneous-sampling converter front end and the capture logic. It holds a 16-bit configuration word. From that word it derives a sample period: one of four master periods, each set in system clock cycles, scaled by 1, 2, 4 or 8. It raises a scan strobe once per period and then emits the samples of the selected channel group. It sends one 16-bit sample per cycle, tagged with its channel number.

A 3-bit mode field picks the group: one channel, the lower pair, the upper pair or all four. Two pair-enable bits decide whether a pair carries real data or reads as grounded (zero). Either of the two power-down bits parks the sequencer. A change to the timing fields, or leaving power-down, restarts the period count so the new timing starts cleanly.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is asserted, `scan_strobe` and `smp_valid` are low and `smp_chan` and `smp_data` are zero.
- R2: Mode code 1xx in config bits [2:0] selects the single channel xx. Each scan then emits exactly one sample, tagged xx.
- R3: Mode code 010 emits channel 0 then channel 1. Mode code 011 emits channel 2 then channel 3.
- R4: Mode code 001 emits channels 0, 1, 2 and 3 in ascending order. The first sample is valid in the cycle after the strobe, and one more follows in each cycle after that.
- R5: Mode code 000 produces no strobes and no samples.
- R6: Consecutive strobes are P cycles apart. P is the master period chosen by bits [4:3] (defaults 8, 11, 12, 16 cycles for codes 0 to 3) shifted left by the value of bits [6:5].
- R7: Two events restart the period count: a change of bits [4:3] or [6:5], and the release of power-down. The first strobe then comes P+2 cycles after the cycle in which the new word is first presented.
- R8: Bit 7 enables channels 0 and 1, and bit 8 enables channels 2 and 3. Samples of a disabled pair are still emitted with their channel tag, but their data is zero.
- R9: While bit 11 (analog power-down) or bit 12 (digital power-down) is set, no strobes and no samples are produced.
- R10: Sample data of an enabled channel equals the 16-bit two's complement input of that channel, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 16 | Configuration word: mode, clock select, divisor shift, pair enables, power-down |
| adc_in | input | 64 | Converter outputs, channel k in bits [16k+15:16k] |
| scan_strobe | output | 1 | One-cycle pulse at each sample boundary |
| smp_valid | output | 1 | A sample is present on `smp_chan` and `smp_data` |
| smp_chan | output | 2 | Channel number of the current sample |
| smp_data | output | 16 | Sample value, two's complement |

## Verification
A configuration word is registered once. The period counter restarts in the next cycle. The first strobe is therefore due P+2 cycles after the word is presented, and later strobes every P cycles. The sample of the k-th channel of a group is due k+1 cycles after its strobe. The bench records the cycle number of every strobe and every sample at the falling edge. It compares each one against these offsets, and compares the sample contents against items queued by the driver in emission order. Quiet modes are watched for a window many periods long, and any strobe or unexpected sample inside it fails.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int NUM_CH = 4;
  localparam int CH_W   = 2;
  localparam int CFG_W  = 16;

  // Field positions inside the configuration word
  localparam int MODE_LSB  = 0;
  localparam int CSEL_LSB  = 3;
  localparam int SHIFT_LSB = 5;
  localparam int EN_LO_POS = 7;
  localparam int EN_HI_POS = 8;
  localparam int PD_A_POS  = 11;
  localparam int PD_D_POS  = 12;

  // Channel group selected by the mode code
  typedef struct packed {
    logic            valid;
    logic [CH_W-1:0] first;
    logic [CH_W-1:0] last;
  } grp_t;

  // Fields that drive the period counter
  typedef struct packed {
    logic       pd;
    logic [1:0] sel;
    logic [1:0] shift;
  } timing_t;

  // Registered copy of the used configuration fields
  typedef struct packed {
    logic [2:0] mode;
    logic [1:0] sel;
    logic [1:0] shift;
    logic [1:0] pair_en;
    logic       pd_a;
    logic       pd_d;
  } cfg_t;

  function automatic grp_t decode_group(input logic [2:0] code);
    grp_t g;
    g = '0;
    casez (code)
      3'b1??: begin g.valid = 1'b1; g.first = code[1:0]; g.last = code[1:0]; end
      3'b010: begin g.valid = 1'b1; g.first = 2'd0;      g.last = 2'd1;      end
      3'b011: begin g.valid = 1'b1; g.first = 2'd2;      g.last = 2'd3;      end
      3'b001: begin g.valid = 1'b1; g.first = 2'd0;      g.last = 2'd3;      end
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/seq_period_gen.sv
module seq_period_gen
  import adc_seq_pkg::*;
#(
  parameter int MCLK0_CYC = 8,
  parameter int MCLK1_CYC = 11,
  parameter int MCLK2_CYC = 12,
  parameter int MCLK3_CYC = 16,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  timing_t          tm,
  output logic             tick,
  output logic [CNT_W-1:0] period
);

  localparam logic [CNT_W-1:0] BASE0 = CNT_W'(MCLK0_CYC);
  localparam logic [CNT_W-1:0] BASE1 = CNT_W'(MCLK1_CYC);
  localparam logic [CNT_W-1:0] BASE2 = CNT_W'(MCLK2_CYC);
  localparam logic [CNT_W-1:0] BASE3 = CNT_W'(MCLK3_CYC);

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  timing_t          tm_q;
  logic             restart;
  logic             cnt_en;

  always_comb begin
    case (tm.sel)
      2'd0:    base = BASE0;
      2'd1:    base = BASE1;
      2'd2:    base = BASE2;
      default: base = BASE3;
    endcase
    period = base << tm.shift;
  end

  // Any timing change or power-down puts the count back to zero
  always_comb begin
    restart = (tm != tm_q) || tm.pd;
    tick    = !restart && (cnt_q == period - CNT_W'(1));
    cnt_en  = 1'b1;
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tm_q  <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      tm_q  <= tm;
    end
  end

  // R7: a restart never coincides with a boundary in the following cycle
  a_r7_restart_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

endmodule

// File: rtl/seq_chan_emitter.sv
module seq_chan_emitter
  import adc_seq_pkg::*;
#(
  parameter int SMP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    abort,
  input  logic                    load,
  input  grp_t                    grp,
  input  logic [NUM_CH*SMP_W-1:0] gated,
  output logic                    smp_valid,
  output logic [CH_W-1:0]         smp_chan,
  output logic [SMP_W-1:0]        smp_data
);

  logic             busy_q, busy_d;
  logic [CH_W-1:0]  cur_q, cur_d;
  logic [CH_W-1:0]  last_q, last_d;
  logic             emit;
  logic             valid_d;
  logic [SMP_W-1:0] data_d;

  always_comb begin
    busy_d  = busy_q;
    cur_d   = cur_q;
    last_d  = last_q;
    emit    = 1'b0;
    valid_d = 1'b0;
    data_d  = gated[cur_q*SMP_W +: SMP_W];
    if (abort) begin
      busy_d = 1'b0;
    end else if (load) begin
      busy_d = 1'b1;
      cur_d  = grp.first;
      last_d = grp.last;
    end else if (busy_q) begin
      emit    = 1'b1;
      valid_d = 1'b1;
      busy_d  = (cur_q != last_q);
      cur_d   = cur_q + CH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cur_q     <= '0;
      last_q    <= '0;
      smp_valid <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      cur_q     <= cur_d;
      last_q    <= last_d;
      smp_valid <= valid_d;
    end
  end

  // Tag and data only move when a sample is emitted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_chan <= '0;
      smp_data <= '0;
    end else if (emit) begin
      smp_chan <= cur_q;
      smp_data <= data_d;
    end
  end

  // R4: consecutive samples step up by one channel
  a_r4_chan_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && $past(smp_valid) |-> smp_chan == $past(smp_chan) + CH_W'(1));

  // R4: a loaded group yields its first sample two cycles later unless aborted
  a_r4_first_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !abort) ##1 !abort |=> smp_valid);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int SMP_W     = 16,
  parameter int MCLK0_CYC = 8,
  parameter int MCLK1_CYC = 11,
  parameter int MCLK2_CYC = 12,
  parameter int MCLK3_CYC = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CFG_W-1:0]        cfg_word,
  input  logic [NUM_CH*SMP_W-1:0] adc_in,
  output logic                    scan_strobe,
  output logic                    smp_valid,
  output logic [CH_W-1:0]         smp_chan,
  output logic [SMP_W-1:0]        smp_data
);

  localparam int MAX01 = (MCLK0_CYC > MCLK1_CYC) ? MCLK0_CYC : MCLK1_CYC;
  localparam int MAX23 = (MCLK2_CYC > MCLK3_CYC) ? MCLK2_CYC : MCLK3_CYC;
  localparam int MAXM  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int CNT_W = $clog2(MAXM * 8 + 1);

  cfg_t                    cfg_q, cfg_d;
  timing_t                 tm;
  grp_t                    grp;
  logic                    pd;
  logic                    tick;
  logic                    strobe_d;
  logic [CNT_W-1:0]        period;
  logic [NUM_CH*SMP_W-1:0] gated;
  logic                    unused_cfg_bits;

  // Configuration register
  always_comb begin
    cfg_d.mode    = cfg_word[MODE_LSB  +: 3];
    cfg_d.sel     = cfg_word[CSEL_LSB  +: 2];
    cfg_d.shift   = cfg_word[SHIFT_LSB +: 2];
    cfg_d.pair_en = {cfg_word[EN_HI_POS], cfg_word[EN_LO_POS]};
    cfg_d.pd_a    = cfg_word[PD_A_POS];
    cfg_d.pd_d    = cfg_word[PD_D_POS];
  end

  assign unused_cfg_bits = ^{cfg_word[15:13], cfg_word[10:9]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    pd       = cfg_q.pd_a | cfg_q.pd_d;
    tm.pd    = pd;
    tm.sel   = cfg_q.sel;
    tm.shift = cfg_q.shift;
    grp      = decode_group(cfg_q.mode);
    strobe_d = tick & grp.valid;
  end

  // A disabled pair reads as grounded
  for (genvar i = 0; i < NUM_CH; i++) begin : g_gate
    assign gated[i*SMP_W +: SMP_W] = cfg_q.pair_en[i/2] ? adc_in[i*SMP_W +: SMP_W] : '0;
  end

  seq_period_gen #(
    .MCLK0_CYC(MCLK0_CYC),
    .MCLK1_CYC(MCLK1_CYC),
    .MCLK2_CYC(MCLK2_CYC),
    .MCLK3_CYC(MCLK3_CYC),
    .CNT_W    (CNT_W)
  ) u_period (
    .clk   (clk),
    .rst_n (rst_n),
    .tm    (tm),
    .tick  (tick),
    .period(period)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scan_strobe <= 1'b0;
    else        scan_strobe <= strobe_d;
  end

  seq_chan_emitter #(
    .SMP_W(SMP_W)
  ) u_emit (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (pd),
    .load     (strobe_d),
    .grp      (grp),
    .gated    (gated),
    .smp_valid(smp_valid),
    .smp_chan (smp_chan),
    .smp_data (smp_data)
  );

  // Independent strobe spacing monitor
  logic [CNT_W-1:0] sep_q;
  logic             sep_ok_q;
  timing_t          chk_tm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sep_q    <= '0;
      sep_ok_q <= 1'b0;
      chk_tm_q <= '0;
    end else begin
      chk_tm_q <= tm;
      if (scan_strobe) sep_q <= '0;
      else             sep_q <= sep_q + CNT_W'(1);
      if (tm != chk_tm_q) sep_ok_q <= 1'b0;
      else if (scan_strobe) sep_ok_q <= 1'b1;
    end
  end

  // R6: strobes keep the selected period
  a_r6_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    scan_strobe && sep_ok_q && (tm == chk_tm_q) |-> sep_q == period - CNT_W'(1));

  // R9: power-down silences the strobe
  a_r9_pd_silent: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> !scan_strobe);

  // R5: an empty group never strobes
  a_r5_none_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !grp.valid |=> !scan_strobe);

  // R8: samples of a disabled pair carry zero
  a_r8_lo_pair_zero: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_chan[1] && !$past(cfg_q.pair_en[0]) |-> smp_data == '0);
  a_r8_hi_pair_zero: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_chan[1] && !$past(cfg_q.pair_en[1]) |-> smp_data == '0);

endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BASE [4] = '{8, 11, 12, 16};
  localparam logic [15:0] ADC0 = 16'h8001;
  localparam logic [15:0] ADC1 = 16'h7FFE;
  localparam logic [15:0] ADC2 = 16'h1234;
  localparam logic [15:0] ADC3 = 16'hFEDC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_word;
  logic [63:0] adc_in;
  logic        scan_strobe;
  logic        smp_valid;
  logic [1:0]  smp_chan;
  logic [15:0] smp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_word   (cfg_word),
    .adc_in     (adc_in),
    .scan_strobe(scan_strobe),
    .smp_valid  (smp_valid),
    .smp_chan   (smp_chan),
    .smp_data   (smp_data)
  );

  typedef struct {
    int          chan;
    logic [15:0] data;
    int          idx;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   strobe_q[$];
  int   cyc = 0;
  int   last_strobe = 0;
  int   tests = 0;
  int   fails = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_cfg(input int mode, input int sel, input int sh,
                                         input bit e0, input bit e1,
                                         input bit pa, input bit pdd);
    logic [15:0] w;
    w = '0;
    w[2:0] = 3'(mode);
    w[4:3] = 2'(sel);
    w[6:5] = 2'(sh);
    w[7]   = e0;
    w[8]   = e1;
    w[11]  = pa;
    w[12]  = pdd;
    return w;
  endfunction

  function automatic logic [15:0] value_of(input int ch, input bit e0, input bit e1);
    logic [15:0] v;
    case (ch)
      0: v = ADC0;
      1: v = ADC1;
      2: v = ADC2;
      default: v = ADC3;
    endcase
    if ((ch < 2 && !e0) || (ch >= 2 && !e1)) v = '0;
    return v;
  endfunction

  // Monitor: records strobes, pops and compares samples
  always @(negedge clk) begin
    if (rst_n) begin
      if (scan_strobe) begin
        strobe_q.push_back(cyc);
        last_strobe = cyc;
      end
      if (smp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5/R9", "unexpected sample channel", int'(smp_chan), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(smp_chan) == e.chan, e.tag, "sample channel", int'(smp_chan), e.chan);
          check(smp_data == e.data, (e.tag == "R8") ? "R8" : "R10", "sample data",
                int'(smp_data), int'(e.data));
          check(cyc == last_strobe + 1 + e.idx, "R4", "sample cycle after strobe",
                cyc - last_strobe, 1 + e.idx);
        end
      end
    end
  end

  // Driver: presents a word, queues expectations, checks strobe timing
  task automatic run_cfg(input int mode, input int sel, input int sh,
                         input bit e0, input bit e1, input int nscans, input string tag);
    int first, last, n, p, c, waited;
    if (mode >= 4)      begin first = mode - 4; last = mode - 4; end
    else if (mode == 2) begin first = 0; last = 1; end
    else if (mode == 3) begin first = 2; last = 3; end
    else                begin first = 0; last = 3; end
    n = last - first + 1;
    p = BASE[sel] << sh;
    for (int s = 0; s < nscans; s++) begin
      for (int ch = first; ch <= last; ch++) begin
        exp_t e;
        e.chan = ch;
        e.data = value_of(ch, e0, e1);
        e.idx  = ch - first;
        e.tag  = tag;
        exp_q.push_back(e);
      end
    end
    strobe_q.delete();
    c = cyc;
    cfg_word = mk_cfg(mode, sel, sh, e0, e1, 1'b0, 1'b0);
    waited = 0;
    while (strobe_q.size() < nscans && waited < (nscans + 2) * p + 10) begin
      @(posedge clk);
      waited++;
    end
    check(strobe_q.size() == nscans, "R6", "strobe count", strobe_q.size(), nscans);
    if (strobe_q.size() > 0)
      check(strobe_q[0] == c + p + 2, "R7", "first strobe delay", strobe_q[0] - c, p + 2);
    for (int k = 1; k < strobe_q.size(); k++)
      check(strobe_q[k] - strobe_q[k-1] == p, "R6", "strobe spacing",
            strobe_q[k] - strobe_q[k-1], p);
    repeat (n) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, tag, "samples outstanding", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic park();
    cfg_word = mk_cfg(1, 0, 0, 1'b1, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
  endtask

  task automatic quiet(input int mode, input bit pa, input bit pdd,
                       input int cycles, input string tag);
    strobe_q.delete();
    cfg_word = mk_cfg(mode, 0, 0, 1'b1, 1'b1, pa, pdd);
    repeat (cycles) @(negedge clk);
    check(strobe_q.size() == 0, tag, "strobes while quiet", strobe_q.size(), 0);
    park();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    adc_in   = {ADC3, ADC2, ADC1, ADC0};
    cfg_word = mk_cfg(1, 0, 0, 1'b1, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(scan_strobe == 1'b0, "R1", "strobe in reset", int'(scan_strobe), 0);
    check(smp_valid == 1'b0, "R1", "valid in reset", int'(smp_valid), 0);
    check(smp_chan == 2'd0 && smp_data == 16'd0, "R1", "sample in reset",
          int'(smp_data), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_cfg(1, 0, 0, 1'b1, 1'b1, 3, "R4"); park();
    run_cfg(6, 1, 1, 1'b1, 1'b1, 2, "R2"); park();
    run_cfg(7, 3, 0, 1'b1, 1'b1, 2, "R2"); park();
    run_cfg(4, 2, 0, 1'b1, 1'b1, 2, "R2"); park();
    run_cfg(2, 2, 2, 1'b1, 1'b1, 2, "R3"); park();
    run_cfg(3, 0, 3, 1'b1, 1'b1, 2, "R3"); park();
    run_cfg(1, 1, 0, 1'b0, 1'b1, 2, "R8"); park();
    run_cfg(3, 3, 1, 1'b1, 1'b0, 1, "R8"); park();
    // R7: timing change without passing through power-down
    run_cfg(1, 0, 0, 1'b1, 1'b1, 1, "R7");
    run_cfg(1, 3, 1, 1'b1, 1'b1, 2, "R7"); park();
    quiet(0, 1'b0, 1'b0, 100, "R5");
    quiet(1, 1'b1, 1'b0, 100, "R9");
    quiet(1, 1'b0, 1'b1, 100, "R9");

    check(exp_q.size() == 0, "R10", "queue drained", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule